// File: doc/BRIEF.md
# Serial Command Latch for a Tape-Deck Front End

This block receives an eleven-bit command word over a three-wire serial link (shift clock, data, load strobe) and presents it as steady control levels to a mixed-signal tape-deck front end. The three serial lines are sampled by the block's system clock. Each rising edge of the serial clock shifts one data bit into a staging register, but only while the load strobe is low. The rising edge of the load strobe copies the staging register into a held register that drives every output.

Eight held bits leave the block as open-drain style controls. Each one is modelled as a logic level plus a pull-low enable, and the released state reads as high. Three held bits stay inside: the playback mute, the gain-control run enable and the deck select. The deck select, one two-level equalizer strap and one three-level equalizer strap together choose the playback time constant and the recording tape type. The three-level strap arrives already digitised as a 2-bit code.

Top module: `serctl_top`

## Requirements
- R1: Data is sampled on each rising serial clock edge while the load strobe is low. The first bit of a frame becomes held bit 0 (D1) and the eleventh becomes held bit 10 (D11).
- R2: Serial clock edges that occur while the load strobe is high shift nothing into the staging register.
- R3: While the load strobe is low, and between loads, every output keeps its value.
- R4: A rising edge of the load strobe copies the staging register into the held register. The outputs change on the third system clock edge after the strobe input rises. The last bit is still captured when its clock falls after the strobe has risen.
- R5: Only the last eleven bits accepted before a load count. If a frame is short, the remaining positions keep bits accepted earlier, shifted along.
- R6: An active-low asynchronous reset sets every held bit and every staging bit to 1. During reset all eight open-drain outputs are released, playback mute is on, gain control runs and deck B is selected.
- R7: `od_level_o[5:0]` carry D1..D6, `od_level_o[6]` carries D9 (1 = 1.7x speed) and `od_level_o[7]` carries D11 (1 = record mute on). `od_pull_o` is the bitwise inverse of `od_level_o`.
- R8: `pb_mute_o` = D7 (1 = mute), `agc_run_o` = D8 (1 = gain control runs), `deck_b_o` = D10 (0 = deck A, 1 = deck B).
- R9: With deck A selected, `pb_tc70_o` equals `aeq_i`. The value 0 selects 120 us and the value 1 selects 70 us.
- R10: With deck B selected, `pb_tc70_o` is 0 (120 us) when `beq_i` is 00 (low), and 1 (70 us) when `beq_i` is 01 (medium) or 1x (high).
- R11: `tape_o` is 00 (normal) for `beq_i` 00, 01 (chrome) for 01, and 10 (metal) for 10 or 11. It never shows 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data |
| ser_latch_i | input | 1 | Load strobe: shift while low, load on rising edge |
| aeq_i | input | 1 | Deck A equalizer strap (0 = 120 us, 1 = 70 us) |
| beq_i | input | 2 | Deck B three-level strap (00 low, 01 medium, 1x high) |
| od_level_o | output | 8 | Logic level of the open-drain controls |
| od_pull_o | output | 8 | Pull-low enable of the open-drain controls |
| pb_mute_o | output | 1 | Playback mute enable |
| agc_run_o | output | 1 | Gain control run enable |
| deck_b_o | output | 1 | Deck select, 1 = deck B |
| pb_tc70_o | output | 1 | Playback time constant, 1 = 70 us |
| tape_o | output | 2 | Recording tape type code |

## Verification
A change on any serial input reaches the synchronised edge detectors two system clock edges later. The staging or held register acts on the third edge, so a load shows at the outputs on the third rising edge after the strobe input rises. The strap decode is combinational and follows `aeq_i` and `beq_i` with no delay. The bench drives inputs on falling clock edges and applies each load to its model exactly three rising edges later. It compares every output a quarter period after each falling edge, which confirms both the load timing and that nothing moves in between.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int FRAME_W = 11;
  localparam int AUX_W = 6;
  localparam int OD_W = AUX_W + 2;
  localparam int B_PB_MUTE = 6;
  localparam int B_AGC_RUN = 7;
  localparam int B_SPEED = 8;
  localparam int B_DECK = 9;
  localparam int B_REC_MUTE = 10;

  typedef enum logic [1:0] {
    TAPE_NORMAL = 2'b00,
    TAPE_CHROME = 2'b01,
    TAPE_METAL  = 2'b10
  } tape_e;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] ch_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ch_q <= {STAGES{RST_VAL[b]}};
      else         ch_q <= {ch_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = ch_q[STAGES-1];
  end
endmodule

// File: rtl/serctl_edge.sv
module serctl_edge #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end
  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/serctl_shift.sv
module serctl_shift #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clk_rise_i,
  input  logic         latch_lvl_i,
  input  logic         bit_i,
  output logic [W-1:0] sh_o
);
  logic [W-1:0] sh_q;
  logic shift_en;
  assign shift_en = clk_rise_i & ~latch_lvl_i;

  // newest bit enters at the top; oldest of the last W ends at bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '1;
    else if (shift_en) sh_q <= {bit_i, sh_q[W-1:1]};
  end
  assign sh_o = sh_q;

  AST_SHIFT_TAKES_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_rise_i && !latch_lvl_i) |=> (sh_q[W-1] == $past(bit_i))); // R1
  AST_NO_SHIFT_LATCH_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_lvl_i |=> $stable(sh_q)); // R2
endmodule

// File: rtl/serctl_hold.sv
module serctl_hold #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '1;
    else if (load_i) q_q <= d_i;
  end
  assign q_o = q_q;

  AST_LOAD_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_q == $past(d_i))); // R4
  AST_HOLD_BETWEEN_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_q)); // R3
endmodule

// File: rtl/serctl_decode.sv
module serctl_decode
  import serctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] held_i,
  input  logic               aeq_i,
  input  logic [1:0]         beq_i,
  output logic [OD_W-1:0]    od_level_o,
  output logic [OD_W-1:0]    od_pull_o,
  output logic               pb_mute_o,
  output logic               agc_run_o,
  output logic               deck_b_o,
  output logic               pb_tc70_o,
  output logic [1:0]         tape_o
);
  tape_e tape;
  logic  beq_not_low;

  for (genvar i = 0; i < AUX_W; i++) begin : g_aux
    assign od_level_o[i] = held_i[i];
  end
  assign od_level_o[AUX_W]   = held_i[B_SPEED];
  assign od_level_o[AUX_W+1] = held_i[B_REC_MUTE];
  assign od_pull_o = ~od_level_o;

  assign pb_mute_o = held_i[B_PB_MUTE];
  assign agc_run_o = held_i[B_AGC_RUN];
  assign deck_b_o  = held_i[B_DECK];

  assign beq_not_low = |beq_i;
  assign pb_tc70_o   = held_i[B_DECK] ? beq_not_low : aeq_i;

  always_comb begin
    unique casez (beq_i)
      2'b00:   tape = TAPE_NORMAL;
      2'b01:   tape = TAPE_CHROME;
      default: tape = TAPE_METAL;
    endcase
  end
  assign tape_o = tape;

  AST_OD_INVERSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    od_pull_o == ~od_level_o); // R7
  AST_DECK_A_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deck_b_o |-> (pb_tc70_o == aeq_i)); // R9
  AST_DECK_B_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deck_b_o |-> (pb_tc70_o == (beq_i != 2'b00))); // R10
  AST_TAPE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tape_o != 2'b11); // R11
endmodule

// File: rtl/serctl_top.sv
module serctl_top
  import serctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ser_clk_i,
  input  logic            ser_data_i,
  input  logic            ser_latch_i,
  input  logic            aeq_i,
  input  logic [1:0]      beq_i,
  output logic [OD_W-1:0] od_level_o,
  output logic [OD_W-1:0] od_pull_o,
  output logic            pb_mute_o,
  output logic            agc_run_o,
  output logic            deck_b_o,
  output logic            pb_tc70_o,
  output logic [1:0]      tape_o
);
  localparam int N_SER = 3;
  localparam logic [N_SER-1:0] SER_RST = 3'b100; // {latch, data, clk}: strobe idles high

  logic [N_SER-1:0]   ser_s;
  logic [1:0]         rise;
  logic [FRAME_W-1:0] sh;
  logic [FRAME_W-1:0] held;

  serctl_sync #(.WIDTH(N_SER), .STAGES(SYNC_STAGES), .RST_VAL(SER_RST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({ser_latch_i, ser_data_i, ser_clk_i}),
    .q_o(ser_s)
  );

  serctl_edge #(.WIDTH(2), .RST_VAL(2'b10)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lvl_i({ser_s[2], ser_s[0]}),
    .rise_o(rise)
  );

  serctl_shift #(.W(FRAME_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clk_rise_i(rise[0]), .latch_lvl_i(ser_s[2]), .bit_i(ser_s[1]),
    .sh_o(sh)
  );

  serctl_hold #(.W(FRAME_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(rise[1]), .d_i(sh), .q_o(held)
  );

  serctl_decode u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .held_i(held), .aeq_i(aeq_i), .beq_i(beq_i),
    .od_level_o(od_level_o), .od_pull_o(od_pull_o),
    .pb_mute_o(pb_mute_o), .agc_run_o(agc_run_o), .deck_b_o(deck_b_o),
    .pb_tc70_o(pb_tc70_o), .tape_o(tape_o)
  );
endmodule

// File: tb/serctl_top_bench.sv
module serctl_top_bench;
  localparam int CLK_P = 10;
  localparam int LAT = 3;  // rising edges from strobe input to outputs
  localparam int PH = 4;   // system cycles per serial phase

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_clk = 1'b0, s_dat = 1'b0, s_lat = 1'b1, aeq = 1'b0;
  logic [1:0] beq = 2'b00;
  logic [7:0] od_level, od_pull;
  logic pb_mute, agc_run, deck_b, pb_tc70;
  logic [1:0] tape;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string scen = "R6";
  bit q[$];
  logic [10:0] exp_h = '1;
  logic [10:0] pend_h = '1;
  int cnt = 0;

  serctl_top u_serctl_top (
    .clk_i(clk), .rst_ni(rst_n),
    .ser_clk_i(s_clk), .ser_data_i(s_dat), .ser_latch_i(s_lat),
    .aeq_i(aeq), .beq_i(beq),
    .od_level_o(od_level), .od_pull_o(od_pull),
    .pb_mute_o(pb_mute), .agc_run_o(agc_run), .deck_b_o(deck_b),
    .pb_tc70_o(pb_tc70), .tape_o(tape)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference: loads apply LAT rising edges after the strobe input rises
  always @(posedge clk) begin
    if (rst_n && cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) exp_h = pend_h;
    end
  end

  function automatic logic [10:0] last11();
    logic [10:0] r;
    for (int i = 0; i < 11; i++) r[i] = q[q.size() - 11 + i];
    return r;
  endfunction

  task automatic chk(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] %s act=%0h exp=%0h @%0t", req, scen, name, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] e_od;
    int e_tc, e_tape;
    e_od = {exp_h[10], exp_h[8], exp_h[5:0]};
    e_tc = exp_h[9] ? int'(beq != 2'b00) : int'(aeq);
    e_tape = (beq == 2'b00) ? 0 : (beq == 2'b01) ? 1 : 2;
    chk("R7", "od_level", od_level, e_od);
    chk("R7", "od_pull", od_pull, ~e_od & 8'hff);
    chk("R8", "pb_mute", pb_mute, exp_h[6]);
    chk("R8", "agc_run", agc_run, exp_h[7]);
    chk("R8", "deck_b", deck_b, exp_h[9]);
    if (exp_h[9]) chk("R10", "pb_tc70", pb_tc70, e_tc);
    else          chk("R9", "pb_tc70", pb_tc70, e_tc);
    chk("R11", "tape", tape, e_tape);
  endtask

  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (!done) compare_all();
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_reset();
    q.delete();
    for (int i = 0; i < 11; i++) q.push_back(1'b1);
    exp_h = '1;
    cnt = 0;
  endtask

  task automatic raise_latch();
    s_lat = 1'b1;
    pend_h = last11();
    cnt = LAT;
  endtask

  // v[0] is sent first; late = strobe rises before the last clock falls
  task automatic send_bits(input logic [31:0] v, input int n, input bit late);
    s_lat = 1'b0;
    idle(PH);
    for (int i = 0; i < n; i++) begin
      s_dat = v[i];
      idle(PH);
      s_clk = 1'b1;
      q.push_back(v[i]);
      idle(PH);
      if (i == n - 1 && late) begin
        raise_latch();
        idle(PH);
      end
      s_clk = 1'b0;
      idle(PH);
    end
    if (!late) raise_latch();
    idle(2 * PH);
  endtask

  initial begin
    model_reset();
    scen = "R6";
    idle(5);
    rst_n = 1'b1;
    idle(4);

    scen = "R1"; send_bits(32'h0000_05A3, 11, 1'b1);
    scen = "R4"; send_bits(32'h0000_025C, 11, 1'b0);
    scen = "R4"; send_bits(32'h0000_0000, 11, 1'b1);

    // walking zero for the bit map
    for (int b = 0; b < 11; b++) begin
      scen = "R7";
      send_bits(~(32'h1 << b), 11, 1'b1);
    end

    // deck A strap decode
    scen = "R9";
    send_bits(32'h0000_0000, 11, 1'b1);
    for (int a = 0; a < 2; a++)
      for (int bq = 0; bq < 4; bq++) begin
        aeq = a[0]; beq = bq[1:0]; idle(3);
      end

    // deck B strap decode
    scen = "R10";
    send_bits(32'h0000_0200, 11, 1'b1);
    for (int a = 0; a < 2; a++)
      for (int bq = 0; bq < 4; bq++) begin
        aeq = a[0]; beq = bq[1:0]; idle(3);
      end
    scen = "R11";
    for (int bq = 3; bq >= 0; bq--) begin
      beq = bq[1:0]; idle(3);
    end

    // over-long and short frames
    scen = "R5"; send_bits(32'h0000_2D6B, 14, 1'b1);
    scen = "R5"; send_bits(32'h0000_0005, 4, 1'b0);

    // clocks while strobe high are ignored
    scen = "R2";
    s_lat = 1'b1;
    for (int i = 0; i < 5; i++) begin
      s_dat = i[0]; idle(PH);
      s_clk = 1'b1; idle(PH);
      s_clk = 1'b0; idle(PH);
    end
    send_bits(32'h0000_0002, 2, 1'b1);

    // reset in mid-frame
    scen = "R3";
    s_lat = 1'b0; idle(PH);
    for (int i = 0; i < 5; i++) begin
      s_dat = 1'b0; idle(PH);
      s_clk = 1'b1; q.push_back(1'b0); idle(PH);
      s_clk = 1'b0; idle(PH);
    end
    scen = "R6";
    rst_n = 1'b0;
    model_reset();
    idle(2);
    s_lat = 1'b1; s_clk = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    send_bits(32'h0000_0000, 3, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule